// File: doc/BRIEF.md
# Distributed Priority Local Arbiter

This block is the local arbiter that one requester places on a shared, open-collector arbitration bus. The bus has one line per priority bit, and a line reads 0 whenever any participant pulls it. A requester raises a shared preempt request. When the arbitrate/grant line next enters its arbitrate state (high), the requester competes. Each bit of its assigned level is compared with the bus, starting at the most significant bit. When a higher-order bit disagrees, the arbiter stops pulling its lower-order bits. When that bit agrees again, it pulls them again. The participant with the numerically lowest level is left alone on the bus, and no central comparator is needed.

When the arbitrate/grant line falls into its grant state (low), the arbiter whose level equals the settled bus reports that it has won. That winner drops preempt and keeps driving its level for the whole grant. It can also hold a burst line until its last transfer. A loser keeps its request pending and competes again at the next arbitration phase. All pulls are registered, so the bus settles one bit per clock.

Top module: `prio_local_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all outputs are 0: `pull_o`, `preempt_o`, `burst_o` and `won_o`.
- R2: `preempt_o` rises in the cycle after `req_i` is seen while the arbiter is idle. The arbiter pulls no bus bit until `arb_phase_i` has gone from 0 to 1 after that point. If `arb_phase_i` is already 1 when the request arrives, the arbiter does not compete in that phase.
- R3: In each clock of the arbitration phase, bit i of `pull_o` is loaded with 1 when level bit i is 0 and every higher bus bit equals the corresponding level bit. The most significant bit is loaded from its level bit alone.
- R4: A mismatch at a higher-order bit removes the pulls of all lower bits from the next cycle on, and the pulls return when that bit matches again. For example, level 0101 against a rival at 1010 gives `pull_o` = 1000, 1000, 1010, 1010 over the first four cycles of the phase.
- R5: With distinct levels, the bus (0 where any participant pulls) settles to the smallest competing level within W+1 cycles of the phase start. From then on, the pulls of every participant are those that R3 gives for that bus value.
- R6: One cycle after `arb_phase_i` falls, `won_o` is 1 exactly when the arbiter was competing and the bus equalled its level. An arbiter that was not competing never wins, even if the bus equals its level.
- R7: The winner's `preempt_o` is 0 whenever `won_o` is 1. A loser keeps `preempt_o` at 1 even if `req_i` is withdrawn, competes again at the next rising edge of `arb_phase_i`, and wins when it is alone.
- R8: While `arb_phase_i` is 0, `pull_o` does not change. The winner keeps driving its level for the whole grant.
- R9: `burst_o` takes the value of `burst_req_i` in the cycle the grant is won. It clears the cycle after `last_xfer_i` is seen during the grant, and it is only ever 1 while `won_o` is 1.
- R10: On the rising edge of `arb_phase_i` that ends its grant, the winner clears `won_o`, `burst_o` and all pulls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request for the bus; held pending once accepted |
| burst_req_i | input | 1 | Ask to keep the bus for a block transfer |
| last_xfer_i | input | 1 | The final command of the block has begun |
| level_i | input | W | Assigned priority level, lower value wins |
| arb_phase_i | input | 1 | 1 = arbitrate, 0 = grant |
| bus_i | input | W | Observed wired arbitration bus |
| pull_o | output | W | Per-bit pull enables onto the wired bus |
| preempt_o | output | 1 | Pull enable for the shared preempt line |
| burst_o | output | 1 | Pull enable for the shared burst line |
| won_o | output | 1 | This requester holds the grant |

## Verification
The busiest cycle is the rising edge of `arb_phase_i` that ends one grant. In that same cycle the previous winner releases its pulls, and the loser, which is still holding its old pulls, starts its next compare against a bus that still shows the winner. The bench provokes this edge for every ordered pair of distinct levels on a bench-wired bus shared by two instances. It then judges that the winner reads zero pulls in the next cycle, and that the loser settles to its own level and takes the following grant. A second coincidence, the burst release on the last transfer while the bus is held, is checked in each of those grants against the burst value requested.

// File: rtl/prio_arb_pkg.sv
`timescale 1ns/1ps
package prio_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ARB   = 2'd2,
        ST_GRANT = 2'd3
    } arb_st_e;
endpackage

// File: rtl/parb_line_edge.sv
`timescale 1ns/1ps
module parb_line_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
    } edge_regs_t;

    edge_regs_t edge_d, edge_q;

    always_comb begin
        edge_d      = edge_q;
        edge_d.prev = line_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '{prev: 1'b1};
        else        edge_q <= edge_d;
    end

    assign rise_o = line_i & ~edge_q.prev;
    assign fall_o = ~line_i & edge_q.prev;
endmodule

// File: rtl/parb_compete_chain.sv
`timescale 1ns/1ps
module parb_compete_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] cand_o,
    output logic         match_all_o
);
    logic [W-1:0] bit_eq;
    logic [W-1:0] enable;

    always_comb begin
        bit_eq       = ~(bus_i ^ level_i);
        enable       = '0;
        enable[W-1]  = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            enable[i] = enable[i+1] & bit_eq[i+1];
        end
    end

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign cand_o[gi] = enable[gi] & ~level_i[gi];
    end

    assign match_all_o = &bit_eq;
endmodule

// File: rtl/parb_fsm.sv
`timescale 1ns/1ps
module parb_fsm
    import prio_arb_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic         burst_req_i,
    input  logic         last_xfer_i,
    input  logic         arb_i,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         match_all_i,
    input  logic [W-1:0] cand_i,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] pull_o,
    output logic         preempt_o,
    output logic         burst_o,
    output logic         won_o
);
    typedef struct packed {
        arb_st_e      st;
        logic [W-1:0] pull;
        logic         preempt;
        logic         burst;
        logic         won;
    } fsm_regs_t;

    localparam fsm_regs_t REGS_RST = '{st: ST_IDLE, pull: '0, preempt: 1'b0,
                                       burst: 1'b0, won: 1'b0};

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    fsm_d.st      = ST_WAIT;
                    fsm_d.preempt = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rise_i) begin
                    fsm_d.st   = ST_ARB;
                    fsm_d.pull = cand_i;
                end
            end
            ST_ARB: begin
                if (fall_i) begin
                    if (match_all_i) begin
                        fsm_d.st      = ST_GRANT;
                        fsm_d.won     = 1'b1;
                        fsm_d.preempt = 1'b0;
                        fsm_d.burst   = burst_req_i;
                    end else begin
                        fsm_d.st = ST_WAIT;
                    end
                end else begin
                    fsm_d.pull = cand_i;
                end
            end
            ST_GRANT: begin
                if (rise_i) begin
                    fsm_d = REGS_RST;
                end else if (last_xfer_i) begin
                    fsm_d.burst = 1'b0;
                end
            end
            default: fsm_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= REGS_RST;
        else        fsm_q <= fsm_d;
    end

    assign pull_o    = fsm_q.pull;
    assign preempt_o = fsm_q.preempt;
    assign burst_o   = fsm_q.burst;
    assign won_o     = fsm_q.won;

    // R3: the top bit follows its level bit on every phase clock
    p_msb_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_ARB && arb_i) |=> (fsm_q.pull[W-1] == !$past(level_i[W-1])))
        else $error("p_msb_drive_r3");

    // R6: a win appears only after a grant edge with the bus equal to the level
    p_won_on_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_q.won) |-> ($past(!arb_i) && $past(bus_i == level_i)))
        else $error("p_won_on_grant_r6");

    // R7: the winner never holds preempt
    p_won_no_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.won |-> !fsm_q.preempt)
        else $error("p_won_no_preempt_r7");

    // R8: pulls are frozen during the grant state of the line
    p_grant_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_i |=> $stable(fsm_q.pull))
        else $error("p_grant_frozen_r8");

    // R9: burst only while the bus is held
    p_burst_with_won_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.burst |-> fsm_q.won)
        else $error("p_burst_with_won_r9");

    // R10: the winner lets go at the next arbitration phase
    p_release_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.won && arb_i) |=> (!fsm_q.won && fsm_q.pull == '0 && !fsm_q.burst))
        else $error("p_release_on_rise_r10");
endmodule

// File: rtl/prio_local_arb.sv
`timescale 1ns/1ps
module prio_local_arb #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic         burst_req_i,
    input  logic         last_xfer_i,
    input  logic [W-1:0] level_i,
    input  logic         arb_phase_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] pull_o,
    output logic         preempt_o,
    output logic         burst_o,
    output logic         won_o
);
    logic         phase_rise;
    logic         phase_fall;
    logic [W-1:0] cand;
    logic         match_all;

    parb_line_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (arb_phase_i),
        .rise_o (phase_rise),
        .fall_o (phase_fall)
    );

    parb_compete_chain #(.W(W)) i_chain (
        .level_i     (level_i),
        .bus_i       (bus_i),
        .cand_o      (cand),
        .match_all_o (match_all)
    );

    parb_fsm #(.W(W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .burst_req_i (burst_req_i),
        .last_xfer_i (last_xfer_i),
        .arb_i       (arb_phase_i),
        .rise_i      (phase_rise),
        .fall_i      (phase_fall),
        .match_all_i (match_all),
        .cand_i      (cand),
        .level_i     (level_i),
        .bus_i       (bus_i),
        .pull_o      (pull_o),
        .preempt_o   (preempt_o),
        .burst_o     (burst_o),
        .won_o       (won_o)
    );
endmodule

// File: tb/test_prio_local_arb.sv
`timescale 1ns/1ps
module test_prio_local_arb;
    localparam int W    = 4;
    localparam int HOLD = W + 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arb_phase = 1'b0;
    logic         req_d = 1'b0, breq_d = 1'b0, last_d = 1'b0;
    logic         req_r = 1'b0, breq_r = 1'b0, last_r = 1'b0;
    logic [W-1:0] lvl_d = '1, lvl_r = '1;
    logic [W-1:0] pull_d, pull_r, bus;
    logic         pre_d, pre_r, bst_d, bst_r, won_d, won_r;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign bus = ~(pull_d | pull_r);

    prio_local_arb #(.W(W)) i_prio_local_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req_d), .burst_req_i(breq_d),
        .last_xfer_i(last_d), .level_i(lvl_d), .arb_phase_i(arb_phase),
        .bus_i(bus), .pull_o(pull_d), .preempt_o(pre_d), .burst_o(bst_d),
        .won_o(won_d)
    );

    prio_local_arb #(.W(W)) i_rival (
        .clk(clk), .rst_n(rst_n), .req_i(req_r), .burst_req_i(breq_r),
        .last_xfer_i(last_r), .level_i(lvl_r), .arb_phase_i(arb_phase),
        .bus_i(bus), .pull_o(pull_r), .preempt_o(pre_r), .burst_o(bst_r),
        .won_o(won_r)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_pull(input int lvl, input int busv);
        int res = 0;
        bit en = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            if (en && !lvl[i]) res |= (1 << i);
            en = en && (busv[i] == lvl[i]);
        end
        return res;
    endfunction

    // Finish both rounds after a phase has been opened and settled.
    task automatic close_rounds();
        arb_phase = 1'b0; tick(1);
        req_d = 1'b0; req_r = 1'b0;
        arb_phase = 1'b1; tick(HOLD);
        arb_phase = 1'b0; tick(1);
        arb_phase = 1'b1; tick(1);
        arb_phase = 1'b0; tick(1);
    endtask

    task automatic run_pair(input int a, input int b);
        int mn;
        bit dw;
        mn = (a < b) ? a : b;
        dw = (a < b);
        lvl_d = W'(a); lvl_r = W'(b);
        breq_d = ((a + b) % 2 == 1); breq_r = !breq_d;
        req_d = 1'b1; req_r = 1'b1;
        tick(2);
        chk("R2 preempt raised", pre_d, 1);
        chk("R2 no pull before phase", pull_d, 0);
        arb_phase = 1'b1; tick(HOLD);
        chk("R5 bus settles to minimum", bus, mn);
        chk("R3 settled pull pattern", pull_d, exp_pull(a, mn));
        arb_phase = 1'b0; tick(1);
        chk("R6 dut won", won_d, dw);
        chk("R6 rival won", won_r, !dw);
        chk("R7 preempt after grant", pre_d, !dw);
        chk("R9 burst at grant", bst_d, dw & breq_d);
        req_d = 1'b0; req_r = 1'b0;
        tick(2);
        chk("R8 bus held in grant", bus, mn);
        last_d = 1'b1; last_r = 1'b1; tick(1);
        last_d = 1'b0; last_r = 1'b0;
        chk("R9 burst released on last", bst_d, 0);
        // end of first grant: winner releases, loser restarts in the same edge
        arb_phase = 1'b1; tick(1);
        chk("R10 won cleared", won_d, 0);
        if (dw) chk("R10 winner pulls released", pull_d, 0);
        else    chk("R7 loser keeps preempt", pre_d, 1);
        tick(HOLD - 1);
        chk("R7 loser alone on bus", bus, dw ? b : a);
        arb_phase = 1'b0; tick(1);
        chk("R7 loser wins second round", won_d, !dw);
        chk("R9 loser burst at grant", bst_d, !dw & breq_d);
        arb_phase = 1'b1; tick(1);
        chk("R10 second release", won_d | bst_d | int'(pull_d != 0), 0);
        arb_phase = 1'b0; tick(1);
        chk("R9 burst idle", bst_d, 0);
    endtask

    initial begin
        tick(3);
        chk("R1 reset pull", pull_d, 0);
        chk("R1 reset flags", {pre_d, bst_d, won_d}, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after reset", {pull_d, pre_d, bst_d, won_d}, 0);

        // R2/R6: request while the phase is already open; level equals idle bus
        arb_phase = 1'b1; tick(1);
        lvl_d = '1; req_d = 1'b1; tick(4);
        chk("R2 preempt while phase open", pre_d, 1);
        chk("R2 no compete in open phase", pull_d, 0);
        arb_phase = 1'b0; tick(1);
        chk("R6 not competing never wins", won_d, 0);
        chk("R7 preempt still pending", pre_d, 1);
        req_d = 1'b0;
        arb_phase = 1'b1; tick(HOLD);
        arb_phase = 1'b0; tick(1);
        chk("R6 competing level wins", won_d, 1);
        arb_phase = 1'b1; tick(1);
        chk("R10 release after solo grant", won_d, 0);
        arb_phase = 1'b0; tick(1);

        // R4: withdraw then resume, 0101 against 1010
        lvl_d = 4'b0101; lvl_r = 4'b1010; req_d = 1'b1; req_r = 1'b1;
        tick(2);
        arb_phase = 1'b1;
        tick(1); chk("R4 resume seq c0", pull_d, 4'b1000);
        tick(1); chk("R4 resume seq c1", pull_d, 4'b1000);
        tick(1); chk("R4 resume seq c2", pull_d, 4'b1010);
        tick(1); chk("R4 resume seq c3", pull_d, 4'b1010);
        close_rounds();

        // R4: the opposite side withdraws its lower bit
        lvl_d = 4'b1010; lvl_r = 4'b0101; req_d = 1'b1; req_r = 1'b1;
        tick(2);
        arb_phase = 1'b1;
        tick(1); chk("R4 withdraw seq c0", pull_d, 4'b0100);
        tick(1); chk("R4 withdraw seq c1", pull_d, 4'b0000);
        tick(1); chk("R4 withdraw seq c2", pull_d, 4'b0000);
        close_rounds();

        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                if (a != b) run_pair(a, b);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule